// File: doc/BRIEF.md
# Floating-Point State Image Writer

This block dumps a snapshot of the floating-point and vector register state into a 512-byte memory image. A start pulse launches the dump. It writes one 16-byte row per accepted cycle through a 128-bit write port that uses a valid/ready handshake. The rows go out in ascending address order from a destination base address. The block reads the scalar control, status, tag and opcode words, the instruction and data pointers with their selectors, the vector control/status register and its mask, eight 80-bit stack registers and sixteen 128-bit vector registers. It reads these sources and never modifies them.

A two-bit layout select picks one of three image shapes:

- **Legacy**: 32-bit pointers with selectors, and eight vector registers.
- **64-bit default**: 32-bit pointers with selectors, and all sixteen vector registers.
- **64-bit wide-pointer**: full 64-bit pointers, no selectors, and all sixteen vector registers.

Before any write, the block checks the precondition faults. It finishes by pulsing either a done flag or a fault flag with a code. The last three rows of the image belong to software, and the block never writes them.

Top module: `fpImageWriter`

## Requirements
- R1: A start with a base address whose low four bits are nonzero raises a one-cycle fault with faultCode 3 (general protection) in the cycle after start, and no row is written.
- R2: Fault precedence is fixed. A clear featureOn or a set lockQual gives code 1 (undefined opcode). Otherwise, a set taskSwitched or emulate gives code 2 (device not available). Otherwise, misalignment gives code 3. faultCode is 0 whenever fault is low.
- R3: Row 0 has the following fields:
  - bits 15:0 hold the control word;
  - bits 31:16 hold the status word;
  - bits 39:32 hold the compressed tag, where bit i is 0 exactly when tagWord[2i+1:2i] is 2'b11 and 1 otherwise;
  - bits 47:40 are zero;
  - bits 63:48 hold opcode[10:0], with the upper 5 bits of the field zero.
- R4: In layouts 0 (legacy), 1 (64-bit default) and 3 (treated as legacy), the pointers sit as follows:
  - row 0 bits 95:64 hold instPtr[31:0], bits 111:96 hold instSel and bits 127:112 are zero;
  - row 1 bits 31:0 hold dataPtr[31:0], bits 47:32 hold dataSel and bits 63:48 are zero.
- R5: In layout 2 (wide pointer), row 0 bits 127:64 hold instPtr and row 1 bits 63:0 hold dataPtr, with no selectors stored.
- R6: When selDeprecate is set in a layout that stores selectors, both selector fields are written as 0000h.
- R7: In every layout, row 1 bits 95:64 hold vecCsr and bits 127:96 hold vecCsrMask.
- R8: Rows 2 to 9 hold stack registers 0 to 7, each with its 80-bit value in bits 79:0 and zeros in bits 127:80.
- R9: Vector registers are placed as follows:
  - rows 10 to 17 hold vector registers 0 to 7 in every layout;
  - rows 18 to 25 hold vector registers 8 to 15 in layouts 1 and 2, and are all zero in the legacy layout;
  - rows 26 to 28 are all zero.
- R10: The row at address base+16*k is written exactly once, for k = 0 to 28. Rows 29 to 31 (bytes 464 to 511) are never written.
- R11: While memValid is high and memReady is low, memValid stays high and memAddr holds. The block advances one row per cycle in which both are high.
- R12: done pulses for one cycle, in the cycle after the last row is accepted. A start that arrives while a dump is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| layoutSel | input | 2 | 0 legacy, 1 64-bit default, 2 wide pointer, 3 legacy |
| baseAddr | input | ADDR_W | Destination byte address |
| ctrlWord | input | 16 | Scalar control word |
| statWord | input | 16 | Scalar status word |
| tagWord | input | 16 | Full two-bit-per-register tag word |
| opcode | input | 16 | Last opcode |
| instPtr | input | 64 | Instruction pointer |
| instSel | input | 16 | Instruction pointer selector |
| dataPtr | input | 64 | Data pointer |
| dataSel | input | 16 | Data pointer selector |
| selDeprecate | input | 1 | Store selectors as zero |
| vecCsr | input | 32 | Vector control/status register |
| vecCsrMask | input | 32 | Writable-bit mask of that register |
| stackRegs | input | 640 | Eight 80-bit stack registers, register i at bits 80i+79:80i |
| vecRegs | input | 2048 | Sixteen 128-bit vector registers, register i at bits 128i+127:128i |
| featureOn | input | 1 | Feature present |
| lockQual | input | 1 | Lock qualifier on the request |
| taskSwitched | input | 1 | Task-switched flag |
| emulate | input | 1 | Emulation flag |
| memValid | output | 1 | Row write request |
| memAddr | output | ADDR_W | Row byte address |
| memData | output | 128 | Row data |
| memReady | input | 1 | Memory accepts the row |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| faultCode | output | 2 | Fault reason while fault is high |

## Verification
The bench goes after the following corner cases, each paired with the failure it would expose:

- **Layout differences.** Each layout is run, and the pointer and selector fields are compared byte for byte. A swapped layout decode would put 64-bit pointers where selectors belong.
- **Tag compression.** The tag word mixes empty codes with the three non-empty codes. An inverted or misordered compression would show up in row 0.
- **Deprecated selectors.** The bench runs with selectors deprecated. A design that ignores selDeprecate would leak the selector values.
- **Legacy upper vectors.** A legacy run checks rows 18 to 25. A design that leaked vector registers 8 to 15 into them would fail.
- **Fault precedence and writes.** Fault combinations are stacked to test precedence. Any fault that still wrote memory would be caught.
- **Stalls and restarts.** Random ready stalls and a second start issued mid-dump expose designs that skip or repeat rows, touch the three software rows, or restart.

// File: rtl/fpimg_pkg.sv
package fpimg_pkg;
  localparam int IMG_BYTES  = 512;
  localparam int ROW_BYTES  = 16;
  localparam int SW_BYTES   = 48;
  localparam int IMG_ROWS   = IMG_BYTES / ROW_BYTES;
  localparam int USED_ROWS  = (IMG_BYTES - SW_BYTES) / ROW_BYTES;
  localparam int ROW_W      = $clog2(IMG_ROWS);
  localparam int OFS_W      = $clog2(ROW_BYTES);
  localparam int STK_N      = 8;
  localparam int STK_W      = 80;
  localparam int VEC_N      = 16;
  localparam int VEC_W      = 128;
  localparam int STK_ROW0   = 2;
  localparam int VEC_ROW0   = STK_ROW0 + STK_N;
  localparam int VEC_HI_ROW = VEC_ROW0 + VEC_N / 2;

  typedef enum logic [1:0] {
    LAY_LEGACY = 2'd0,
    LAY_DEF64  = 2'd1,
    LAY_WIDE   = 2'd2,
    LAY_ALT    = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_NM   = 2'd2,
    FLT_GP   = 2'd3
  } fault_e;

  typedef struct packed {
    logic             latch;
    logic             emit;
    logic [ROW_W-1:0] row;
  } strobe_t;
endpackage

// File: rtl/fpimg_ctrl.sv
module fpimg_ctrl
  import fpimg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              featureOn,
  input  logic              lockQual,
  input  logic              taskSwitched,
  input  logic              emulate,
  input  logic              memReady,
  output strobe_t           strb,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCode
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(USED_ROWS - 1);

  logic             busy;
  logic [ROW_W-1:0] rowQ;
  fault_e           chkCode;

  always_comb begin
    if (!featureOn || lockQual)      chkCode = FLT_UD;
    else if (taskSwitched || emulate) chkCode = FLT_NM;
    else if (baseAddr[OFS_W-1:0] != '0) chkCode = FLT_GP;
    else                              chkCode = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      rowQ      <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      faultCode <= FLT_NONE;
    end else begin
      done      <= 1'b0;
      fault     <= 1'b0;
      faultCode <= FLT_NONE;
      if (!busy) begin
        if (start) begin
          if (chkCode != FLT_NONE) begin
            fault     <= 1'b1;
            faultCode <= chkCode;
          end else begin
            busy <= 1'b1;
            rowQ <= '0;
          end
        end
      end else if (memReady) begin
        if (rowQ == LAST_ROW) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rowQ <= rowQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.latch = !busy && start && (chkCode == FLT_NONE);
    strb.emit  = busy;
    strb.row   = rowQ;
  end
endmodule

// File: rtl/fpimg_dpath.sv
module fpimg_dpath
  import fpimg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [1:0]             layoutSel,
  input  logic [ADDR_W-1:0]      baseAddr,
  input  logic [15:0]            ctrlWord,
  input  logic [15:0]            statWord,
  input  logic [15:0]            tagWord,
  input  logic [15:0]            opcode,
  input  logic [63:0]            instPtr,
  input  logic [15:0]            instSel,
  input  logic [63:0]            dataPtr,
  input  logic [15:0]            dataSel,
  input  logic                   selDeprecate,
  input  logic [31:0]            vecCsr,
  input  logic [31:0]            vecCsrMask,
  input  logic [STK_N*STK_W-1:0] stackRegs,
  input  logic [VEC_N*VEC_W-1:0] vecRegs,
  output logic                   memValid,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [VEC_W-1:0]       memData
);
  logic [ADDR_W-1:0] baseQ;
  layout_e           layQ;
  logic [STK_W-1:0]  stk [STK_N];
  logic [VEC_W-1:0]  vec [VEC_N];
  logic [7:0]        tagShort;
  logic [15:0]       iSelEff, dSelEff;
  logic              wideQ, legacyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      layQ  <= LAY_LEGACY;
    end else if (strb.latch) begin
      baseQ <= baseAddr;
      layQ  <= layout_e'(layoutSel);
    end
  end

  for (genvar i = 0; i < STK_N; i++) begin : g_stk
    assign stk[i] = stackRegs[i*STK_W +: STK_W];
  end
  for (genvar i = 0; i < VEC_N; i++) begin : g_vec
    assign vec[i] = vecRegs[i*VEC_W +: VEC_W];
  end
  for (genvar i = 0; i < 8; i++) begin : g_tag
    assign tagShort[i] = (tagWord[2*i +: 2] != 2'b11);
  end

  assign wideQ   = (layQ == LAY_WIDE);
  assign legacyQ = (layQ == LAY_LEGACY) || (layQ == LAY_ALT);
  assign iSelEff = selDeprecate ? 16'h0 : instSel;
  assign dSelEff = selDeprecate ? 16'h0 : dataSel;

  always_comb begin
    int r;
    r       = int'(strb.row);
    memData = '0;
    if (r == 0) begin
      memData[15:0]  = ctrlWord;
      memData[31:16] = statWord;
      memData[39:32] = tagShort;
      memData[63:48] = {5'b0, opcode[10:0]};
      if (wideQ) memData[127:64] = instPtr;
      else begin
        memData[95:64]  = instPtr[31:0];
        memData[111:96] = iSelEff;
      end
    end else if (r == 1) begin
      if (wideQ) memData[63:0] = dataPtr;
      else begin
        memData[31:0]  = dataPtr[31:0];
        memData[47:32] = dSelEff;
      end
      memData[95:64]  = vecCsr;
      memData[127:96] = vecCsrMask;
    end else if (r < VEC_ROW0) begin
      memData[STK_W-1:0] = stk[r - STK_ROW0];
    end else if (r < VEC_HI_ROW) begin
      memData = vec[r - VEC_ROW0];
    end else if (r < VEC_ROW0 + VEC_N) begin
      if (!legacyQ) memData = vec[r - VEC_ROW0];
    end
  end

  assign memValid = strb.emit;
  assign memAddr  = baseQ + {{(ADDR_W-ROW_W-OFS_W){1'b0}}, strb.row, {OFS_W{1'b0}}};
endmodule

// File: rtl/fpImageWriter.sv
module fpImageWriter
  import fpimg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             layoutSel,
  input  logic [ADDR_W-1:0]      baseAddr,
  input  logic [15:0]            ctrlWord,
  input  logic [15:0]            statWord,
  input  logic [15:0]            tagWord,
  input  logic [15:0]            opcode,
  input  logic [63:0]            instPtr,
  input  logic [15:0]            instSel,
  input  logic [63:0]            dataPtr,
  input  logic [15:0]            dataSel,
  input  logic                   selDeprecate,
  input  logic [31:0]            vecCsr,
  input  logic [31:0]            vecCsrMask,
  input  logic [STK_N*STK_W-1:0] stackRegs,
  input  logic [VEC_N*VEC_W-1:0] vecRegs,
  input  logic                   featureOn,
  input  logic                   lockQual,
  input  logic                   taskSwitched,
  input  logic                   emulate,
  output logic                   memValid,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [VEC_W-1:0]       memData,
  input  logic                   memReady,
  output logic                   done,
  output logic                   fault,
  output logic [1:0]             faultCode
);
  strobe_t strb;

  fpimg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .featureOn(featureOn), .lockQual(lockQual), .taskSwitched(taskSwitched),
    .emulate(emulate), .memReady(memReady), .strb(strb), .done(done),
    .fault(fault), .faultCode(faultCode)
  );

  fpimg_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .layoutSel(layoutSel),
    .baseAddr(baseAddr), .ctrlWord(ctrlWord), .statWord(statWord),
    .tagWord(tagWord), .opcode(opcode), .instPtr(instPtr), .instSel(instSel),
    .dataPtr(dataPtr), .dataSel(dataSel), .selDeprecate(selDeprecate),
    .vecCsr(vecCsr), .vecCsrMask(vecCsrMask), .stackRegs(stackRegs),
    .vecRegs(vecRegs), .memValid(memValid), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/fpImageWriterChk.sv
module fpImageWriterChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic              fault,
  input logic [1:0]        faultCode
);
  AST_ROW_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memAddr[3:0] == 4'h0) else $error("row address misaligned"); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr)) else $error("stall not held"); // R11
  AST_ADVANCE_ROW: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady ##1 memValid |-> memAddr == $past(memAddr) + 16) else $error("row skipped"); // R11
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !memValid && !done) else $error("fault with write"); // R1
  AST_CODE_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 2'd0) == fault) else $error("fault code mismatch"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R12
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid && $past(memValid && memReady)) else $error("done without last row"); // R12
endmodule

bind fpImageWriter fpImageWriterChk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fpImageWriter.sv
module sim_fpImageWriter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] layoutSel = 2'd0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [15:0] ctrlWord, statWord, tagWord, opcode, instSel, dataSel;
  logic [63:0] instPtr, dataPtr;
  logic selDeprecate = 1'b0;
  logic [31:0] vecCsr, vecCsrMask;
  logic [639:0] stackRegs;
  logic [2047:0] vecRegs;
  logic featureOn = 1'b1, lockQual = 1'b0, taskSwitched = 1'b0, emulate = 1'b0;
  logic memValid, memReady;
  logic [ADDR_W-1:0] memAddr;
  logic [127:0] memData;
  logic done, fault;
  logic [1:0] faultCode;

  int tests = 0;
  int fails = 0;
  logic [127:0] mem [32];
  int wrCount = 0;
  int badAddr = 0;
  int doneCount = 0;
  bit randReady = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [ADDR_W-1:0] curBase = '0;
  localparam logic [127:0] FILL = {4{32'hA5C3_5A3C}};

  always #(CLK_PERIOD/2) clk = ~clk;

  fpImageWriter #(.ADDR_W(ADDR_W)) u0 (.*);

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady <= randReady ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (rstN && memValid && memReady) begin
      logic [ADDR_W-1:0] off;
      off = memAddr - curBase;
      if (off[3:0] != 0 || off >= 512) badAddr <= badAddr + 1;
      else mem[off[8:4]] <= memData;
      wrCount <= wrCount + 1;
    end
    if (rstN && done) doneCount <= doneCount + 1;
  end

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expRow(int lay, int r, bit dep);
    logic [127:0] e;
    bit wide, leg;
    e = '0;
    wide = (lay == 2);
    leg = (lay == 0) || (lay == 3);
    if (r == 0) begin
      e[15:0] = ctrlWord;
      e[31:16] = statWord;
      for (int i = 0; i < 8; i++) e[32+i] = (tagWord[2*i +: 2] != 2'b11);
      e[63:48] = {5'b0, opcode[10:0]};
      if (wide) e[127:64] = instPtr;
      else begin e[95:64] = instPtr[31:0]; e[111:96] = dep ? 16'h0 : instSel; end
    end else if (r == 1) begin
      if (wide) e[63:0] = dataPtr;
      else begin e[31:0] = dataPtr[31:0]; e[47:32] = dep ? 16'h0 : dataSel; end
      e[95:64] = vecCsr;
      e[127:96] = vecCsrMask;
    end else if (r <= 9) e[79:0] = stackRegs[(r-2)*80 +: 80];
    else if (r <= 17) e = vecRegs[(r-10)*128 +: 128];
    else if (r <= 25) e = leg ? '0 : vecRegs[(r-10)*128 +: 128];
    else if (r <= 28) e = '0;
    else e = FILL;
    return e;
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 32; i++) mem[i] = FILL;
    wrCount = 0; badAddr = 0; doneCount = 0;
  endtask

  task automatic pulseStart(logic [ADDR_W-1:0] base);
    @(negedge clk);
    baseAddr = base; curBase = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runSave(int lay, logic [ADDR_W-1:0] base, bit dep, bit rnd, bit restart, string tag);
    int n;
    clearMem();
    layoutSel = 2'(lay); selDeprecate = dep; randReady = rnd;
    pulseStart(base);
    n = 0;
    while (!done && n < 3000) begin
      if (restart && n == 5) start = 1'b1; else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && doneCount == 1, {tag, " R12 single done"}, 128'(doneCount), 128'd1);
    check(wrCount == 29 && badAddr == 0, {tag, " R10 write count"}, 128'(wrCount), 128'd29);
    for (int r = 0; r < 32; r++) begin
      logic [127:0] e;
      e = expRow(lay, r, dep);
      if (mem[r] !== e) begin
        tests++; fails++;
        $display("FAIL %s R3/R4/R5/R6/R7/R8/R9/R10 row %0d actual=%h expected=%h", tag, r, mem[r], e);
      end
    end
    tests++;
  endtask

  task automatic runFault(logic [ADDR_W-1:0] base, bit feat, bit lck, bit ts, bit em, logic [1:0] expCode, string tag);
    bit seen;
    logic [1:0] code;
    clearMem();
    featureOn = feat; lockQual = lck; taskSwitched = ts; emulate = em;
    pulseStart(base);
    seen = fault; code = faultCode;
    repeat (5) @(negedge clk);
    check(seen && code == expCode, tag, 128'(code), 128'(expCode));
    check(wrCount == 0 && fault == 0 && faultCode == 0, {tag, " R1 no write"}, 128'(wrCount), 128'd0);
    featureOn = 1'b1; lockQual = 1'b0; taskSwitched = 1'b0; emulate = 1'b0;
  endtask

  initial begin
    ctrlWord = 16'h037F; statWord = 16'h3820; tagWord = 16'b11_00_01_11_10_11_00_11;
    opcode = 16'hFFDB; instPtr = 64'h1122_3344_5566_7788; instSel = 16'h0023;
    dataPtr = 64'h99AA_BBCC_DDEE_F001; dataSel = 16'h002B;
    vecCsr = 32'h0000_1F80; vecCsrMask = 32'h0000_FFFF;
    for (int i = 0; i < 8; i++) stackRegs[i*80 +: 80] = {16'h4000 + 16'(i), 64'hC90F_DAA2_2168_C234 ^ 64'(i*7919)};
    for (int i = 0; i < 16; i++) vecRegs[i*128 +: 128] = {32'(i), 32'hDEAD_0000 | 32'(i), 32'h0BAD_F00D, 32'(i*i+1)};
    repeat (3) @(negedge clk);
    check(memValid == 0 && done == 0 && fault == 0 && faultCode == 0, "reset R12", {memValid, done, fault}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    runSave(0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "legacy R4 R9");
    runSave(1, 32'h0000_2210, 1'b0, 1'b1, 1'b0, "def64 R4 R9 R11");
    runSave(2, 32'h0000_30F0, 1'b0, 1'b1, 1'b0, "wide R5");
    runSave(0, 32'h0000_4000, 1'b1, 1'b0, 1'b0, "legacy deprecate R6");
    runSave(1, 32'h0000_5000, 1'b1, 1'b1, 1'b0, "def64 deprecate R6");
    runSave(3, 32'h0000_6000, 1'b0, 1'b0, 1'b1, "alt restart R12");
    tagWord = 16'hFFFF; opcode = 16'h07FF;
    runSave(2, 32'h0000_7000, 1'b1, 1'b0, 1'b0, "wide empty tags R3");
    runFault(32'h0000_1008, 1, 0, 0, 0, 2'd3, "misaligned R1");
    runFault(32'h0000_1000, 1, 0, 1, 0, 2'd2, "task switched R2");
    runFault(32'h0000_1000, 1, 0, 0, 1, 2'd2, "emulate R2");
    runFault(32'h0000_1000, 0, 0, 0, 0, 2'd1, "feature off R2");
    runFault(32'h0000_1004, 1, 1, 1, 1, 2'd1, "lock precedence R2");
    runFault(32'h0000_1001, 1, 0, 1, 0, 2'd2, "nm over gp R2");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule